// File: doc/BRIEF.md
# Interleaved Byte Stream Selector

The selector sits on a byte stream that carries several configuration images woven together in fixed-size chunks. The first chunk comes from image 1, the next from image 2, and so on up to the last image, after which the rotation starts again at image 1. The block passes on only the bytes of one chosen image, in their original order, and discards every other byte inside the block.

A single-cycle start pulse captures the image count and the 1-based index of the wanted image, then clears the position tracking. From then on, input bytes flow through a valid/ready interface. Bytes of foreign images are taken one per clock, whatever the downstream side is doing. Bytes of the wanted image reach the output in the same cycle and wait on the output's ready. An error marker from the upstream source goes to the consumer in place of a data byte. A running count of combined-stream data bytes taken is visible on an output port. The chunk position is tracked by an offset counter and a rotating image counter, so no divider is needed.

Top module: `image_stream_select`

## Requirements
- R1: After reset and before the first start pulse, `in_ready` and `out_valid` are 0 and `consumed_cnt` is 0.
- R2: A cycle with `start`=1 captures `cfg_count` and `cfg_sel`, holds `in_ready` at 0 for that cycle, and leaves `consumed_cnt` at 0 and the chunk position at offset 0 of image 1 in the next cycle. This applies even when a stream is already in progress.
- R3: The data byte with index k since the last start (k counting from 0) belongs to image ((k / CHUNK_BYTES) mod count) + 1. Only bytes whose image equals the captured selection appear on the output, with `out_data` equal to the input byte and `out_err`=0.
- R4: A data byte of a foreign image is accepted in the cycle it is presented (`in_ready`=1 regardless of `out_ready`), and `out_valid` stays 0 for it.
- R5: For a byte of the selected image, `out_valid` follows `in_valid` in the same cycle. `in_ready` equals `out_ready`, so the byte is held at the input while the output is stalled, and order is kept.
- R6: `consumed_cnt` increases by exactly 1 for every data byte taken at the input, whether forwarded or dropped, and is otherwise unchanged between start pulses.
- R7: An input word with `in_err`=1 is shown to the consumer as `out_valid`=1, `out_err`=1, whatever the current chunk's owner is, and is taken when `out_ready`=1. It advances neither `consumed_cnt` nor the chunk position.
- R8: Changes to `cfg_count` or `cfg_sel` outside a start cycle do not change which bytes are forwarded.
- R9: With an image count of 1, every data byte is forwarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Single-cycle pulse that captures the configuration and begins a new selection |
| cfg_count | input | IMG_W | Number of interleaved images (1..MAX_IMAGES) |
| cfg_sel | input | IMG_W | 1-based index of the image to keep |
| in_valid | input | 1 | Combined-stream word present |
| in_data | input | 8 | Combined-stream byte |
| in_err | input | 1 | Word is an upstream error marker, not a data byte |
| in_ready | output | 1 | Word is taken at this clock edge |
| out_valid | output | 1 | Selected byte or error marker present |
| out_data | output | 8 | Selected byte |
| out_err | output | 1 | Output word is an error marker |
| out_ready | input | 1 | Consumer takes the output word |
| consumed_cnt | output | CNT_W | Data bytes taken from the combined stream since the last start |

## Verification
The bench builds the block with a chunk size of 4, up to 4 images and a 16-bit counter. With these values, many chunk boundaries and several full rotations of the image counter fit into streams of a few dozen bytes. Selecting the last image, image counts of 1 and 3, a restart in mid-stream, and error markers that arrive during a foreign chunk are all reachable within a short run. Stall patterns on the output mix drop cycles with held selected bytes.

// File: rtl/isel_pkg.sv
package isel_pkg;
  // advance a position counter that wraps back to zero at lim
  function automatic int unsigned wrap_next(int unsigned v, int unsigned lim);
    return (v + 1 >= lim) ? 0 : v + 1;
  endfunction

  // true when the offset is the last byte of a chunk
  function automatic logic at_chunk_end(int unsigned off, int unsigned chunk);
    return (off + 1 >= chunk);
  endfunction
endpackage

// File: rtl/isel_tracker.sv
module isel_tracker #(
  parameter int CHUNK_BYTES = 288,
  parameter int MAX_IMAGES  = 8,
  parameter int CNT_W       = 32,
  localparam int OFF_W      = $clog2(CHUNK_BYTES),
  localparam int IMG_W      = $clog2(MAX_IMAGES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [IMG_W-1:0] count_d,
  input  logic [IMG_W-1:0] sel_d,
  input  logic             take_byte,
  output logic             wanted,
  output logic [OFF_W-1:0] offs_q,
  output logic [IMG_W-1:0] img_q,
  output logic [IMG_W-1:0] sel_q,
  output logic [CNT_W-1:0] cnt_q
);
  logic [IMG_W-1:0] count_q;
  logic             chunk_end;

  assign chunk_end = isel_pkg::at_chunk_end(32'(offs_q), CHUNK_BYTES);
  assign wanted    = ({1'b0, img_q} + 1'b1) == {1'b0, sel_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      offs_q  <= '0;
      img_q   <= '0;
      sel_q   <= '0;
      count_q <= '0;
      cnt_q   <= '0;
    end else if (start) begin
      offs_q  <= '0;
      img_q   <= '0;
      sel_q   <= sel_d;
      count_q <= count_d;
      cnt_q   <= '0;
    end else if (take_byte) begin
      cnt_q  <= cnt_q + 1'b1;
      offs_q <= OFF_W'(isel_pkg::wrap_next(32'(offs_q), CHUNK_BYTES));
      if (chunk_end)
        img_q <= IMG_W'(isel_pkg::wrap_next(32'(img_q), 32'(count_q)));
    end
  end
endmodule

// File: rtl/isel_flow.sv
module isel_flow (
  input  logic active,
  input  logic in_valid,
  input  logic in_err,
  input  logic wanted,
  input  logic out_ready,
  output logic in_ready,
  output logic out_valid,
  output logic out_err,
  output logic take_byte,
  output logic fwd_byte,
  output logic drop_byte,
  output logic pass_err
);
  logic needs_sink;

  assign needs_sink = in_err | wanted;
  assign pass_err   = active & in_valid & in_err;
  assign fwd_byte   = active & in_valid & ~in_err & wanted;
  assign drop_byte  = active & in_valid & ~in_err & ~wanted;
  assign out_valid  = fwd_byte | pass_err;
  assign out_err    = pass_err;
  assign in_ready   = active & (needs_sink ? out_ready : 1'b1);
  assign take_byte  = in_valid & in_ready & ~in_err;
endmodule

// File: rtl/image_stream_select.sv
module image_stream_select #(
  parameter int CHUNK_BYTES = 288,
  parameter int MAX_IMAGES  = 8,
  parameter int CNT_W       = 32,
  localparam int OFF_W      = $clog2(CHUNK_BYTES),
  localparam int IMG_W      = $clog2(MAX_IMAGES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [IMG_W-1:0] cfg_count,
  input  logic [IMG_W-1:0] cfg_sel,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  input  logic             in_err,
  output logic             in_ready,
  output logic             out_valid,
  output logic [7:0]       out_data,
  output logic             out_err,
  input  logic             out_ready,
  output logic [CNT_W-1:0] consumed_cnt
);
  logic             active_q;
  logic             active;
  logic             wanted;
  logic             take_byte;
  logic             fwd_byte;
  logic             drop_byte;
  logic             pass_err;
  logic [OFF_W-1:0] offs_q;
  logic [IMG_W-1:0] img_q;
  logic [IMG_W-1:0] sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     active_q <= 1'b0;
    else if (start) active_q <= 1'b1;
  end

  assign active = active_q & ~start;

  isel_tracker #(
    .CHUNK_BYTES(CHUNK_BYTES),
    .MAX_IMAGES (MAX_IMAGES),
    .CNT_W      (CNT_W)
  ) u_track (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .count_d  (cfg_count),
    .sel_d    (cfg_sel),
    .take_byte(take_byte),
    .wanted   (wanted),
    .offs_q   (offs_q),
    .img_q    (img_q),
    .sel_q    (sel_q),
    .cnt_q    (consumed_cnt)
  );

  isel_flow u_flow (
    .active   (active),
    .in_valid (in_valid),
    .in_err   (in_err),
    .wanted   (wanted),
    .out_ready(out_ready),
    .in_ready (in_ready),
    .out_valid(out_valid),
    .out_err  (out_err),
    .take_byte(take_byte),
    .fwd_byte (fwd_byte),
    .drop_byte(drop_byte),
    .pass_err (pass_err)
  );

  assign out_data = in_data;
endmodule

// File: rtl/isel_checker.sv
module isel_checker #(
  parameter int CHUNK_BYTES = 288,
  parameter int CNT_W       = 32,
  parameter int OFF_W       = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             active_q,
  input logic             in_valid,
  input logic             in_err,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic             take_byte,
  input logic             drop_byte,
  input logic [OFF_W-1:0] offs_q,
  input logic [CNT_W-1:0] consumed_cnt
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !active_q |-> (!in_ready && !out_valid)); // R1
  AST_START_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !in_ready); // R2
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (consumed_cnt == '0)); // R2
  AST_DROP_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    drop_byte |-> (in_ready && !out_valid)); // R4
  AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready); // R5
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (take_byte && !start) |=> (consumed_cnt == CNT_W'($past(consumed_cnt) + 1'b1))); // R6
  AST_CNT_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    (!take_byte && !start) |=> $stable(consumed_cnt)); // R6
  AST_ERR_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_err && in_ready && !start) |=> ($stable(consumed_cnt) && $stable(offs_q))); // R7

  always_comb begin
    if (rst_n) AST_OFF_RANGE: assert (32'(offs_q) < CHUNK_BYTES); // R3
  end
endmodule

bind image_stream_select isel_checker #(
  .CHUNK_BYTES(CHUNK_BYTES),
  .CNT_W      (CNT_W),
  .OFF_W      (OFF_W)
) u_isel_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .active_q    (active_q),
  .in_valid    (in_valid),
  .in_err      (in_err),
  .in_ready    (in_ready),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .take_byte   (take_byte),
  .drop_byte   (drop_byte),
  .offs_q      (offs_q),
  .consumed_cnt(consumed_cnt)
);

// File: tb/test_image_stream_select.sv
`timescale 1ns/1ps
module test_image_stream_select;
  localparam int CH    = 4;
  localparam int MAXI  = 4;
  localparam int CW    = 16;
  localparam int IW    = $clog2(MAXI + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [IW-1:0] cfg_count = '0;
  logic [IW-1:0] cfg_sel = '0;
  logic          in_valid = 1'b0;
  logic [7:0]    in_data = '0;
  logic          in_err = 1'b0;
  logic          in_ready;
  logic          out_valid;
  logic [7:0]    out_data;
  logic          out_err;
  logic          out_ready = 1'b0;
  logic [CW-1:0] consumed_cnt;

  int n_checks = 0;
  int n_fail   = 0;
  int cur_sel  = 1;
  int cur_cnt  = 1;

  always #2.5 clk = ~clk;

  image_stream_select #(.CHUNK_BYTES(CH), .MAX_IMAGES(MAXI), .CNT_W(CW)) i_image_stream_select (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_count(cfg_count), .cfg_sel(cfg_sel),
    .in_valid(in_valid), .in_data(in_data), .in_err(in_err), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .out_err(out_err), .out_ready(out_ready),
    .consumed_cnt(consumed_cnt)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit owns(input int k);
    return ((k / CH) % cur_cnt) + 1 == cur_sel;
  endfunction

  task automatic do_start(input int cnt, input int sel);
    @(negedge clk);
    in_valid = 1'b1; in_err = 1'b0; in_data = 8'h5A; out_ready = 1'b1;
    start = 1'b1; cfg_count = IW'(cnt); cfg_sel = IW'(sel);
    #1 chk(!in_ready && !out_valid, "R2 start cycle takes nothing", int'(in_ready), 0);
    @(negedge clk);
    start = 1'b0; in_valid = 1'b0;
    cur_cnt = cnt; cur_sel = sel;
    #1 chk(consumed_cnt == 0, "R2 counter cleared", int'(consumed_cnt), 0);
  endtask

  // stream n bytes with indices k0.. ; stall pulls out_ready low every third cycle
  task automatic run_stream(input int k0, input int n, input bit stall);
    int k = k0;
    int cyc = 0;
    while (k < k0 + n) begin
      @(negedge clk);
      in_valid = 1'b1; in_err = 1'b0; in_data = 8'(k);
      out_ready = stall ? (cyc % 3 != 0) : 1'b1;
      cyc++;
      #1;
      if (owns(k)) begin
        if (!out_ready)
          chk(!in_ready && out_valid && out_data == 8'(k), "R5 held while stalled", int'(in_ready), 0);
        else begin
          chk(in_ready && out_valid && !out_err && out_data == 8'(k), "R3 selected byte forwarded",
              int'(out_data), k % 256);
          k++;
        end
      end else begin
        chk(in_ready && !out_valid, "R4 foreign byte dropped", int'(out_valid), 0);
        k++;
      end
    end
    @(negedge clk);
    in_valid = 1'b0; out_ready = 1'b1;
    #1 chk(consumed_cnt == CW'(k0 + n), "R6 byte count", int'(consumed_cnt), k0 + n);
  endtask

  task automatic t_reset();
    @(negedge clk);
    in_valid = 1'b1; out_ready = 1'b1;
    #1 chk(!in_ready && !out_valid && consumed_cnt == 0, "R1 idle after reset", int'(in_ready), 0);
    @(negedge clk);
    in_valid = 1'b0;
    #1 chk(consumed_cnt == 0, "R1 nothing taken before start", int'(consumed_cnt), 0);
  endtask

  task automatic t_basic();
    do_start(3, 2);
    run_stream(0, 40, 1'b0);
  endtask

  task automatic t_stalled_last();
    do_start(4, 4);
    run_stream(0, 48, 1'b1);
  endtask

  task automatic t_single();
    do_start(1, 1);
    run_stream(0, 20, 1'b1); // R9 every byte owned
  endtask

  task automatic t_error();
    do_start(2, 2);
    @(negedge clk);
    in_valid = 1'b1; in_err = 1'b1; in_data = 8'hEE; out_ready = 1'b0;
    #1 chk(out_valid && out_err && !in_ready, "R7 error shown while stalled", int'(out_valid), 1);
    @(negedge clk);
    out_ready = 1'b1;
    #1 chk(in_ready && out_valid && out_err, "R7 error taken", int'(in_ready), 1);
    @(negedge clk);
    in_valid = 1'b0; in_err = 1'b0;
    #1 chk(consumed_cnt == 0, "R7 error not counted", int'(consumed_cnt), 0);
    run_stream(0, 12, 1'b0); // position unaffected by the error word
  endtask

  task automatic t_cfg_ignored();
    do_start(2, 1);
    @(negedge clk);
    cfg_count = IW'(3); cfg_sel = IW'(2);
    run_stream(0, 20, 1'b0); // R8 still selects image 1 of 2
  endtask

  task automatic t_restart();
    do_start(3, 1);
    run_stream(0, 10, 1'b0);
    do_start(3, 3); // R2 mid-stream restart
    run_stream(0, 30, 1'b1);
  endtask

  initial begin
    #(5.0 * 100000);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_stalled_last();
    t_single();
    t_error();
    t_cfg_ignored();
    t_restart();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule